// File: doc/BRIEF.md
# Programmable threshold level flags for a dual-clock queue

This block produces the two "nearly there" indicators for one direction of a dual-clock queue of 36-bit words. The write side pulses `wr_inc` once per word stored into the memory, and the read side pulses `rd_inc` once per word taken out of it. The block keeps both pointers and hands out their low bits as memory addresses. It carries each pointer across to the other clock in Gray code, and compares the two in binary against run-time offsets. The write-side threshold is `y_off` and the read-side threshold is `x_off`. The queue memory itself, the loading of the offsets and any bypass path are outside this block.

`af_n` is registered in the write clock domain. It goes low when the stored word count comes within `y_off` of the depth. `ae_n` is registered in the read clock domain. It goes low while the count is at or below `x_off`. A word that the read side has already moved into its output register counts as read, because `rd_inc` marks the moment it leaves memory.

A change made by a flag's own port shows on the next edge of that flag's clock. A change made by the opposite port takes two rising edges of the flag's clock. The first edge captures the crossed pointer and the second registers the flag. If an opposite-port event comes too close to an own-clock edge, that edge may not capture it, and the update then slips by one cycle. The depth parameter is meant to be 256, 512 or 1024.

Top module: `fifo_level_flags`

## Requirements
- R1: While `wrst` and `rrst` are high, and after they are released, the block is in its cleared state until the first increment. In that state both pointers are zero, `wr_addr` and `rd_addr` read 0, `ae_n` is 0 and `af_n` is 1.
- R2: Once both clocks have settled, `ae_n` is 0 when the word count (write increments minus read increments) is at most `x_off`, and 1 when the count is `x_off`+1 or more.
- R3: Once both clocks have settled, `af_n` is 0 when the word count is at least DEPTH−`y_off`, and 1 when it is at most DEPTH−`y_off`−1. With `y_off` = 0, `af_n` is low only at a count of DEPTH.
- R4: After a write raises the count from `x_off` to `x_off`+1, `ae_n` stays 0 through the first rising `rclk` edge that follows the write. It becomes 1 on the second rising `rclk` edge.
- R5: After a read lowers the count from DEPTH−`y_off` to DEPTH−`y_off`−1, `af_n` stays 0 through the first rising `wclk` edge that follows the read. It becomes 1 on the second rising `wclk` edge.
- R6: A write that raises the count to DEPTH−`y_off` drives `af_n` to 0 on the same `wclk` edge that accepts the write. A read that lowers the count to `x_off` drives `ae_n` to 0 on the same `rclk` edge that accepts the read.
- R7: `wr_addr` and `rd_addr` each advance by one per accepted increment and wrap modulo DEPTH. The crossed pointers change by at most one Gray bit per cycle.
- R8: A new `y_off` value takes effect on `af_n` at the next rising `wclk` edge. A new `x_off` value takes effect on `ae_n` at the next rising `rclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Synchronous active-high reset, write side |
| wr_inc | input | 1 | One word stored into memory this cycle |
| y_off | input | log2(DEPTH) | Almost-full offset |
| af_n | output | 1 | Almost-full flag, active low, write clock |
| wr_addr | output | log2(DEPTH) | Memory write address |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Synchronous active-high reset, read side |
| rd_inc | input | 1 | One word taken out of memory this cycle |
| x_off | input | log2(DEPTH) | Almost-empty offset |
| ae_n | output | 1 | Almost-empty flag, active low, read clock |
| rd_addr | output | log2(DEPTH) | Memory read address |

## Verification
A pointer that is miscounted or badly crossed shows up as a flag threshold that sits one or more words off. The bench finds this within a single step of a full-depth fill and drain sweep, because it checks both flags and both addresses at every count from 0 to DEPTH. A synchronizer stage that is missing or extra moves the opposite-port deassertion one edge early or late. The edge-by-edge probes around the thresholds catch that, as well as a flag that is slow to respond to its own port or to an offset change.

// File: rtl/lvlflag_pkg.sv
package lvlflag_pkg;

  // Which comparison a level flag performs.
  typedef enum logic {
    SIDE_EMPTY = 1'b0,
    SIDE_FULL  = 1'b1
  } side_e;

endpackage

// File: rtl/lf_gray_ptr.sv
module lf_gray_ptr #(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [PW-1:0] bin,
  output logic [PW-1:0] bin_nxt,
  output logic [PW-1:0] gray
);

  assign bin_nxt = bin + {{(PW-1){1'b0}}, inc};

  always_ff @(posedge clk) begin
    if (rst) begin
      bin  <= '0;
      gray <= '0;
    end else begin
      bin  <= bin_nxt;
      gray <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  // R7: the crossing value moves by one Gray bit at most
  a_r7_gray_one_bit: assert property (@(posedge clk) disable iff (rst)
    $countones(gray ^ $past(gray)) <= 1);

  // R7: the binary pointer advances by zero or one per cycle
  a_r7_bin_step: assert property (@(posedge clk) disable iff (rst)
    (bin - $past(bin)) <= PW'(1));

endmodule

// File: rtl/lf_gray_sync.sv
module lf_gray_sync #(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);

  logic [PW-1:0] cap;

  // Capture stage; the consuming flag register is the second stage.
  always_ff @(posedge clk) begin
    if (rst) cap <= '0;
    else     cap <= gray_in;
  end

  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign bin_out[i] = ^cap[PW-1:i];
  end

endmodule

// File: rtl/lf_level_flag.sv
module lf_level_flag #(
  parameter int                 DEPTH = 256,
  parameter lvlflag_pkg::side_e SIDE  = lvlflag_pkg::SIDE_EMPTY,
  localparam int                AW    = $clog2(DEPTH),
  localparam int                PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] near_bin,
  input  logic [PW-1:0] near_nxt,
  input  logic [PW-1:0] far_bin,
  input  logic [AW-1:0] offset,
  output logic          flag_n
);

  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);
  localparam logic          RST_VAL = (SIDE == lvlflag_pkg::SIDE_FULL);

  logic [PW-1:0] fill_nxt;
  logic          trip;

  if (SIDE == lvlflag_pkg::SIDE_FULL) begin : g_full
    assign fill_nxt = near_nxt - far_bin;
    assign trip     = fill_nxt >= (DEPTH_V - {1'b0, offset});

    // R3: a full queue holding still keeps the flag low
    a_r3_low_at_full: assert property (@(posedge clk) disable iff (rst)
      ((near_bin - far_bin) == DEPTH_V && near_nxt == near_bin) |=> !flag_n);
  end else begin : g_empty
    assign fill_nxt = far_bin - near_nxt;
    assign trip     = fill_nxt <= {1'b0, offset};

    // R2: an empty queue keeps the flag low
    a_r2_low_at_empty: assert property (@(posedge clk) disable iff (rst)
      (far_bin == near_bin) |=> !flag_n);
  end

  always_ff @(posedge clk) begin
    if (rst) flag_n <= RST_VAL;
    else     flag_n <= !trip;
  end

  // R1: the flag leaves reset at its idle level
  a_r1_reset_level: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flag_n == RST_VAL));

  // R4, R5: deassertion only follows a crossed pointer move or an offset change
  a_r5_rise_needs_far_event: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_n) |-> ($past(far_bin) != $past(far_bin, 2)) ||
                      ($past(offset) != $past(offset, 2)));

endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int  DEPTH = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          wr_inc,
  input  logic [AW-1:0] y_off,
  output logic          af_n,
  output logic [AW-1:0] wr_addr,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          rd_inc,
  input  logic [AW-1:0] x_off,
  output logic          ae_n,
  output logic [AW-1:0] rd_addr
);

  localparam int PW = AW + 1;

  logic [PW-1:0] w_bin, w_nxt, w_gray, r_seen_in_w;
  logic [PW-1:0] r_bin, r_nxt, r_gray, w_seen_in_r;

  lf_gray_ptr #(.PW(PW)) u_wptr (
    .clk(wclk), .rst(wrst), .inc(wr_inc),
    .bin(w_bin), .bin_nxt(w_nxt), .gray(w_gray)
  );

  lf_gray_ptr #(.PW(PW)) u_rptr (
    .clk(rclk), .rst(rrst), .inc(rd_inc),
    .bin(r_bin), .bin_nxt(r_nxt), .gray(r_gray)
  );

  lf_gray_sync #(.PW(PW)) u_r2w (
    .clk(wclk), .rst(wrst), .gray_in(r_gray), .bin_out(r_seen_in_w)
  );

  lf_gray_sync #(.PW(PW)) u_w2r (
    .clk(rclk), .rst(rrst), .gray_in(w_gray), .bin_out(w_seen_in_r)
  );

  lf_level_flag #(.DEPTH(DEPTH), .SIDE(lvlflag_pkg::SIDE_FULL)) u_af (
    .clk(wclk), .rst(wrst), .near_bin(w_bin), .near_nxt(w_nxt),
    .far_bin(r_seen_in_w), .offset(y_off), .flag_n(af_n)
  );

  lf_level_flag #(.DEPTH(DEPTH), .SIDE(lvlflag_pkg::SIDE_EMPTY)) u_ae (
    .clk(rclk), .rst(rrst), .near_bin(r_bin), .near_nxt(r_nxt),
    .far_bin(w_seen_in_r), .offset(x_off), .flag_n(ae_n)
  );

  assign wr_addr = w_bin[AW-1:0];
  assign rd_addr = r_bin[AW-1:0];

endmodule

// File: tb/fifo_level_flags_test.sv
module fifo_level_flags_test;

  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst = 1'b1, rrst = 1'b1;
  logic wr_inc = 1'b0, rd_inc = 1'b0;
  logic [AW-1:0] y_off = '0, x_off = '0;
  logic af_n, ae_n;
  logic [AW-1:0] wr_addr, rd_addr;

  int total = 0, bad = 0;
  int count = 0, wtot = 0, rtot = 0;
  int cur_x = 0, cur_y = 0;
  bit finished = 0;

  fifo_level_flags #(.DEPTH(DEPTH)) uut (
    .wclk(wclk), .wrst(wrst), .wr_inc(wr_inc), .y_off(y_off),
    .af_n(af_n), .wr_addr(wr_addr),
    .rclk(rclk), .rrst(rrst), .rd_inc(rd_inc), .x_off(x_off),
    .ae_n(ae_n), .rd_addr(rd_addr)
  );

  // 125 MHz on both sides; rclk rises 2 ns after wclk
  always #4 wclk = ~wclk;
  initial begin
    #2;
    forever #4 rclk = ~rclk;
  end

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s count=%0d actual=%0d expected=%0d", req, count, got, exp);
    end
  endtask

  task automatic do_reset();
    wr_inc = 0; rd_inc = 0;
    wrst = 1; rrst = 1;
    repeat (4) @(negedge wclk);
    wrst = 0; rrst = 0;
    count = 0; wtot = 0; rtot = 0;
  endtask

  task automatic do_write();
    @(negedge wclk) wr_inc = 1;
    @(negedge wclk) wr_inc = 0;
    count++; wtot++;
  endtask

  task automatic do_read();
    @(negedge rclk) rd_inc = 1;
    @(negedge rclk) rd_inc = 0;
    count--; rtot++;
  endtask

  task automatic settle();
    repeat (4) @(negedge wclk);
  endtask

  task automatic set_off(input int x, input int y);
    @(negedge wclk);
    x_off = AW'(x); y_off = AW'(y);
    cur_x = x; cur_y = y;
    settle();
  endtask

  task automatic check_levels();
    check("R2 ae_n level", int'(ae_n), (count > cur_x) ? 1 : 0);
    check("R3 af_n level", int'(af_n), (count >= DEPTH - cur_y) ? 0 : 1);
    check("R7 wr_addr", int'(wr_addr), wtot % DEPTH);
    check("R7 rd_addr", int'(rd_addr), rtot % DEPTH);
  endtask

  task automatic fill_to(input int n);
    while (count < n) do_write();
    while (count > n) do_read();
    settle();
  endtask

  task automatic sweep(input int x, input int y);
    set_off(x, y);
    check_levels();
    for (int i = 0; i < DEPTH; i++) begin
      do_write(); settle(); check_levels();
    end
    for (int i = 0; i < DEPTH; i++) begin
      do_read(); settle(); check_levels();
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge wclk);
    check("R1 ae_n after reset", int'(ae_n), 0);
    check("R1 af_n after reset", int'(af_n), 1);
    check("R1 wr_addr after reset", int'(wr_addr), 0);
    check("R1 rd_addr after reset", int'(rd_addr), 0);

    // R4: two read edges after a write crossing x_off
    set_off(5, 10);
    fill_to(5);
    check("R2 ae_n at x", int'(ae_n), 0);
    do_write();
    check("R4 ae_n after first rclk edge", int'(ae_n), 0);
    @(posedge rclk); #1;
    check("R4 ae_n after second rclk edge", int'(ae_n), 1);

    // R6: own-port read drops ae_n at once
    settle();
    do_read();
    check("R6 ae_n on own read", int'(ae_n), 0);

    // R5: two write edges after a read crossing depth - y_off
    fill_to(DEPTH - 10);
    check("R3 af_n at threshold", int'(af_n), 0);
    do_read();
    check("R5 af_n right after read", int'(af_n), 0);
    @(posedge wclk); #1;
    check("R5 af_n after first wclk edge", int'(af_n), 0);
    @(posedge wclk); #1;
    check("R5 af_n after second wclk edge", int'(af_n), 1);

    // R6: own-port write drops af_n at once
    settle();
    do_write();
    check("R6 af_n on own write", int'(af_n), 0);

    // R8: offset changes take effect at the next own edge
    settle();
    @(negedge wclk) y_off = AW'(5);
    @(posedge wclk); #1;
    check("R8 af_n after y_off raise", int'(af_n), 1);
    @(negedge wclk) y_off = AW'(10);
    @(posedge wclk); #1;
    check("R8 af_n after y_off restore", int'(af_n), 0);
    @(negedge rclk) x_off = AW'(DEPTH - 10);
    @(posedge rclk); #1;
    check("R8 ae_n after x_off raise", int'(ae_n), 0);
    @(negedge rclk) x_off = AW'(DEPTH - 11);
    @(posedge rclk); #1;
    check("R8 ae_n after x_off lower", int'(ae_n), 1);

    // R1: reset with words stored
    do_reset();
    @(negedge wclk);
    check("R1 ae_n after mid-run reset", int'(ae_n), 0);
    check("R1 af_n after mid-run reset", int'(af_n), 1);
    check("R1 wr_addr after mid-run reset", int'(wr_addr), 0);
    check("R1 rd_addr after mid-run reset", int'(rd_addr), 0);

    // R2, R3, R7: full-depth sweeps over several offset pairs
    sweep(0, 0);
    sweep(1, 255);
    sweep(255, 1);
    sweep(8, 8);
    sweep(100, 37);
    sweep(200, 128);

    // R7: address wrap past one lap
    repeat (3) do_write();
    settle();
    check_levels();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule